// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block recovers stereo PCM samples from a three-wire serial audio link in which the link partner drives all clocks. The link carries a bit clock, a frame clock that marks the left and right halves of each frame, and one or more data lines that share those two clocks. The receiver runs on a faster system clock and finds bit-clock edges by oversampling. It supports three framings (I2S, left-justified, right-justified) and four word lengths (16, 18, 20, 24 bits).

Each channel half-frame is a 32-bit-clock slot. Where the word starts inside the slot depends on the framing and, for right-justified data, on the word length, so the last data bit lands on the last bit clock of the slot. A received word goes out MSB-aligned in a 24-bit field, with zeros below it. Once the right word of a frame is complete, the left and right words of every data line come out together with a single-cycle valid pulse.

Top module: `pcm_serial_rx`

## Requirements
- R1: While `rst` is high on a clock edge, and in the cycles after it until a frame completes, `valid_out` is 0 and every bit of `left_out` and `right_out` is 0. Reset in the middle of traffic clears earlier results.
- R2: With `fmt_sel` = 0 (I2S), the word's MSB is the bit sampled on the second bit-clock rising edge after a frame-clock transition.
- R3: With `fmt_sel` = 1 (left-justified), the word's MSB is the bit sampled on the first bit-clock rising edge after a frame-clock transition.
- R4: With `fmt_sel` = 2 (right-justified), the MSB is at slot position 32 - N, where position 0 is the first rising edge after the transition and N is the word length. The LSB is therefore at slot position 31.
- R5: `wlen_sel` selects N: 0 gives 16, 1 gives 18, 2 gives 20 and 3 gives 24 bits. The N received bits fill output bits 23 down to 24 - N, MSB first, and the bits below them are 0.
- R6: Bits outside the N-bit window of a slot have no effect on any output, whatever their value.
- R7: Bits sampled while the frame clock is low form the left word (`left_out`). Bits sampled while it is high form the right word (`right_out`).
- R8: Exactly one `valid_out` pulse, one system clock wide, is produced per frame, after the right word's LSB. `left_out` and `right_out` change only in a cycle where `valid_out` is 1.
- R9: Each data line `sdata_in[i]` is deserialized independently into bits [24*i+23 : 24*i] of `left_out` and `right_out`, using the shared bit clock and frame clock.
- R10: `fmt_sel` = 3 frames data the same way as I2S.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the serial clocks |
| rst | input | 1 | Synchronous active-high reset |
| bclk_in | input | 1 | Serial bit clock (asynchronous to clk) |
| frclk_in | input | 1 | Frame clock: low = left, high = right |
| sdata_in | input | NUM_LINES (2) | Serial data lines, MSB first |
| fmt_sel | input | 2 | Framing: 0 I2S, 1 left-justified, 2 right-justified, 3 as I2S |
| wlen_sel | input | 2 | Word length: 0=16, 1=18, 2=20, 3=24 bits |
| left_out | output | NUM_LINES*24 (48) | Left words, line i at [24i+23:24i] |
| right_out | output | NUM_LINES*24 (48) | Right words, line i at [24i+23:24i] |
| valid_out | output | 1 | One-cycle pulse when a full frame is present |

## Verification
A wrong slot-position count shows within the same frame as a word shifted by one or more bit positions, or as bits picked up from outside the window. This is visible on the outputs at the next valid pulse, and each format and word length needs its own stimulus. A wrong channel register or capture-window end shows up as a missing or doubled valid pulse within one frame, or as left and right words swapped. Junk bits are driven outside the window so that an over-wide window corrupts the low, zero-filled bits. Each data line carries different words, so crossed lanes are caught.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_ALT = 2'd3
  } fmt_e;

  // Word length code to bit count
  function automatic logic [5:0] wlen_bits(input logic [1:0] sel);
    case (sel)
      2'd0:    return 6'd16;
      2'd1:    return 6'd18;
      2'd2:    return 6'd20;
      default: return 6'd24;
    endcase
  endfunction

endpackage

// File: rtl/pcm_rx_sync.sv
module pcm_rx_sync #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stab_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_in;
      stab_q <= meta_q;
    end
  end

  assign sync_out = stab_q;

endmodule

// File: rtl/pcm_rx_slot_ctrl.sv
module pcm_rx_slot_ctrl
  import pcm_rx_pkg::*;
#(
  parameter int SLOT_BITS = 32,
  parameter int CNT_W     = $clog2(SLOT_BITS) + 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bclk_s,
  input  logic       frclk_s,
  input  logic [1:0] fmt_sel,
  input  logic [1:0] wlen_sel,
  output logic       shift_en,
  output logic       first_bit,
  output logic       done_l,
  output logic       done_r,
  output logic       chan
);

  localparam logic [CNT_W-1:0] POS_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] SLOT_LEN = CNT_W'(SLOT_BITS);

  logic             bclk_q;
  logic             chan_q;
  logic [CNT_W-1:0] pos_q;
  logic             rise;
  logic             new_slot;
  logic [CNT_W-1:0] pos_nxt;
  logic [CNT_W-1:0] wl;
  logic [CNT_W-1:0] start;
  logic [CNT_W-1:0] stop;
  logic             in_win;
  logic             last_bit;

  assign rise     = bclk_s & ~bclk_q;
  assign new_slot = (frclk_s != chan_q);

  always_comb begin
    if (new_slot)             pos_nxt = '0;
    else if (pos_q == POS_MAX) pos_nxt = POS_MAX;
    else                      pos_nxt = pos_q + 1'b1;
  end

  assign wl = CNT_W'(wlen_bits(wlen_sel));

  always_comb begin
    case (fmt_e'(fmt_sel))
      FMT_LJ:  start = '0;
      FMT_RJ:  start = SLOT_LEN - wl;
      default: start = CNT_W'(1);
    endcase
  end

  assign stop      = start + wl;
  assign in_win    = (pos_nxt >= start) && (pos_nxt < stop);
  assign shift_en  = rise & in_win;
  assign first_bit = shift_en & (pos_nxt == start);
  assign last_bit  = shift_en & (pos_nxt == stop - 1'b1);
  assign done_l    = last_bit & ~frclk_s;
  assign done_r    = last_bit & frclk_s;
  assign chan      = chan_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_q <= 1'b0;
      chan_q <= 1'b1;
      pos_q  <= POS_MAX;
    end else begin
      bclk_q <= bclk_s;
      if (rise) begin
        chan_q <= frclk_s;
        pos_q  <= pos_nxt;
      end
    end
  end

  // R4
  slot_window_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |-> (pos_nxt < SLOT_LEN));

  // R8
  single_done_chk: assert property (@(posedge clk) disable iff (rst)
    done_r |=> !done_r);

endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane
  import pcm_rx_pkg::*;
#(
  parameter int OUT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sd,
  input  logic [1:0]       wlen_sel,
  input  logic             shift_en,
  input  logic             first_bit,
  input  logic             done_l,
  input  logic             done_r,
  output logic [OUT_W-1:0] left_word,
  output logic [OUT_W-1:0] right_word
);

  localparam int SH_W = $clog2(OUT_W) + 1;

  logic [OUT_W-1:0] acc_q;
  logic [OUT_W-1:0] acc_nxt;
  logic [OUT_W-1:0] aligned;
  logic [OUT_W-1:0] left_hold_q;
  logic [OUT_W-1:0] left_q;
  logic [OUT_W-1:0] right_q;
  logic [SH_W-1:0]  sh;

  always_comb begin
    if (first_bit) acc_nxt = {{(OUT_W-1){1'b0}}, sd};
    else           acc_nxt = {acc_q[OUT_W-2:0], sd};
  end

  assign sh      = SH_W'(OUT_W) - SH_W'(wlen_bits(wlen_sel));
  assign aligned = acc_nxt << sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q       <= '0;
      left_hold_q <= '0;
      left_q      <= '0;
      right_q     <= '0;
    end else begin
      if (shift_en) acc_q <= acc_nxt;
      if (done_l)   left_hold_q <= aligned;
      if (done_r) begin
        left_q  <= left_hold_q;
        right_q <= aligned;
      end
    end
  end

  assign left_word  = left_q;
  assign right_word = right_q;

  // R5
  low_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (done_r && wlen_sel == 2'd0) |=> (right_q[OUT_W-17:0] == '0));

endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
  import pcm_rx_pkg::*;
#(
  parameter int NUM_LINES = 2,
  parameter int OUT_W     = 24,
  parameter int SLOT_BITS = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bclk_in,
  input  logic                       frclk_in,
  input  logic [NUM_LINES-1:0]       sdata_in,
  input  logic [1:0]                 fmt_sel,
  input  logic [1:0]                 wlen_sel,
  output logic [NUM_LINES*OUT_W-1:0] left_out,
  output logic [NUM_LINES*OUT_W-1:0] right_out,
  output logic                       valid_out
);

  localparam int SYNC_W = NUM_LINES + 2;

  logic [SYNC_W-1:0]    sync_v;
  logic                 bclk_s;
  logic                 frclk_s;
  logic [NUM_LINES-1:0] sd_s;
  logic                 shift_en;
  logic                 first_bit;
  logic                 done_l;
  logic                 done_r;
  logic                 chan;
  logic                 valid_q;

  // Data goes through the same two flops as the clocks to keep alignment
  pcm_rx_sync #(.WIDTH(SYNC_W)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in ({sdata_in, frclk_in, bclk_in}),
    .sync_out (sync_v)
  );

  assign bclk_s  = sync_v[0];
  assign frclk_s = sync_v[1];
  assign sd_s    = sync_v[SYNC_W-1:2];

  pcm_rx_slot_ctrl #(.SLOT_BITS(SLOT_BITS)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .bclk_s    (bclk_s),
    .frclk_s   (frclk_s),
    .fmt_sel   (fmt_sel),
    .wlen_sel  (wlen_sel),
    .shift_en  (shift_en),
    .first_bit (first_bit),
    .done_l    (done_l),
    .done_r    (done_r),
    .chan      (chan)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_lane
    pcm_rx_lane #(.OUT_W(OUT_W)) u_lane (
      .clk        (clk),
      .rst        (rst),
      .sd         (sd_s[i]),
      .wlen_sel   (wlen_sel),
      .shift_en   (shift_en),
      .first_bit  (first_bit),
      .done_l     (done_l),
      .done_r     (done_r),
      .left_word  (left_out[i*OUT_W +: OUT_W]),
      .right_word (right_out[i*OUT_W +: OUT_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= done_r;
  end

  assign valid_out = valid_q;

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    valid_out |=> !valid_out);

  // R7
  valid_right_chan_chk: assert property (@(posedge clk) disable iff (rst)
    valid_out |-> chan);

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_out |-> ($stable(right_out) && $stable(left_out)));

endmodule

// File: tb/sim_pcm_serial_rx.sv
`timescale 1ns/1ps
module sim_pcm_serial_rx;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bclk = 1'b0;
  logic        frclk = 1'b1;
  logic [1:0]  sdata = 2'b00;
  logic [1:0]  fmt = 2'd0;
  logic [1:0]  wsel = 2'd3;
  logic [47:0] left_out;
  logic [47:0] right_out;
  logic        valid_out;

  int n_chk = 0;
  int n_bad = 0;
  int vcount = 0;
  int dbl = 0;
  logic prev_v = 1'b0;
  logic [47:0] cap_l = '0;
  logic [47:0] cap_r = '0;

  always #4 clk = ~clk;

  pcm_serial_rx u0 (
    .clk       (clk),
    .rst       (rst),
    .bclk_in   (bclk),
    .frclk_in  (frclk),
    .sdata_in  (sdata),
    .fmt_sel   (fmt),
    .wlen_sel  (wsel),
    .left_out  (left_out),
    .right_out (right_out),
    .valid_out (valid_out)
  );

  always @(negedge clk) begin
    if (valid_out) begin
      vcount++;
      cap_l = left_out;
      cap_r = right_out;
      if (prev_v) dbl++;
    end
    prev_v = valid_out;
  end

  function automatic int wbits(input logic [1:0] w);
    case (w)
      2'd0: return 16;
      2'd1: return 18;
      2'd2: return 20;
      default: return 24;
    endcase
  endfunction

  function automatic logic [23:0] expect_word(input logic [23:0] s, input logic [1:0] w);
    int n = wbits(w);
    logic [23:0] m = (24'h1 << n) - 24'h1;
    return (s & m) << (24 - n);
  endfunction

  function automatic logic bitval(input logic [23:0] s, input int n, input int st,
                                  input int p, input logic junk);
    if (p >= st && p < st + n) return s[n - 1 - (p - st)];
    return junk;
  endfunction

  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_frame(input logic [1:0] f, input logic [1:0] w,
                            input logic [23:0] l0, input logic [23:0] r0,
                            input logic [23:0] l1, input logic [23:0] r1,
                            input logic junk);
    int n = wbits(w);
    int st = (f == 2'd2) ? 32 - n : ((f == 2'd1) ? 0 : 1);
    fmt = f;
    wsel = w;
    for (int ch = 0; ch < 2; ch++) begin
      for (int p = 0; p < 32; p++) begin
        frclk = (ch == 1);
        sdata[0] = bitval((ch == 1) ? r0 : l0, n, st, p, junk);
        sdata[1] = bitval((ch == 1) ? r1 : l1, n, st, p, junk);
        bclk = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        bclk = 1'b1;
        repeat (4) @(posedge clk);
        #1;
      end
    end
    bclk = 1'b0;
    repeat (6) @(posedge clk);
    #1;
  endtask

  task automatic frame_check(input string tag, input logic [1:0] f, input logic [1:0] w,
                             input logic [23:0] l0, input logic [23:0] r0,
                             input logic [23:0] l1, input logic [23:0] r1,
                             input logic junk);
    vcount = 0;
    dbl = 0;
    send_frame(f, w, l0, r0, l1, r1, junk);
    chk({tag, " R8 valid count"}, 48'(vcount), 48'd1);
    chk({tag, " R8 single-cycle valid"}, 48'(dbl), 48'd0);
    chk({tag, " R7 left words"}, cap_l, {expect_word(l1, w), expect_word(l0, w)});
    chk({tag, " R7 right words"}, cap_r, {expect_word(r1, w), expect_word(r0, w)});
  endtask

  task automatic t_reset();
    chk("R1 reset valid", {47'd0, valid_out}, 48'd0);
    chk("R1 reset left", left_out, 48'd0);
    chk("R1 reset right", right_out, 48'd0);
  endtask

  task automatic t_lj();
    frame_check("R3 lj24", 2'd1, 2'd3, 24'h9A5C31, 24'h123456, 24'hF0F0AA, 24'h0FED81, 1'b0);
  endtask

  task automatic t_i2s();
    frame_check("R2 i2s24", 2'd0, 2'd3, 24'hC3A501, 24'h7E8100, 24'h55AA33, 24'h800001, 1'b0);
    frame_check("R2 i2s16", 2'd0, 2'd0, 24'h00BEEF, 24'h008001, 24'h001234, 24'h00FFFE, 1'b0);
  endtask

  task automatic t_rj();
    frame_check("R4 R5 rj16", 2'd2, 2'd0, 24'h00A5C3, 24'h0081FF, 24'h00137F, 24'h00FEDC, 1'b1);
    frame_check("R4 R5 rj18", 2'd2, 2'd1, 24'h02B3C4, 24'h01FFFF, 24'h030001, 24'h0155AA, 1'b1);
    frame_check("R4 R5 rj20", 2'd2, 2'd2, 24'h0ABCDE, 24'h08000F, 24'h0F1E2D, 24'h012345, 1'b1);
    frame_check("R4 R5 rj24", 2'd2, 2'd3, 24'hD00DAD, 24'h7FFFFF, 24'h800000, 24'h3C3C3C, 1'b0);
  endtask

  task automatic t_junk();
    frame_check("R6 lj16 junk", 2'd1, 2'd0, 24'h004321, 24'h00A0A0, 24'h00FFFF, 24'h000001, 1'b1);
    frame_check("R6 i2s20 junk", 2'd0, 2'd2, 24'h0F00F0, 24'h0AAAAA, 24'h055555, 24'h000000, 1'b1);
    chk("R6 i2s20 low bits", {44'd0, cap_r[3:0]}, 48'd0);
  endtask

  task automatic t_lanes();
    frame_check("R9 lanes", 2'd1, 2'd1, 24'h000000, 24'h3FFFF, 24'h3FFFF, 24'h000000, 1'b0);
    chk("R9 lane0 left", {24'd0, cap_l[23:0]}, 48'd0);
    chk("R9 lane1 left", {24'd0, cap_l[47:24]}, {24'd0, 24'hFFFFC0});
  endtask

  task automatic t_alt_fmt();
    frame_check("R10 fmt3", 2'd3, 2'd3, 24'h6B2C9E, 24'hA1B2C3, 24'h010203, 24'hFEDCBA, 1'b0);
  endtask

  task automatic t_mid_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    rst = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 mid reset left", left_out, 48'd0);
    chk("R1 mid reset right", right_out, 48'd0);
    chk("R1 mid reset valid", {47'd0, valid_out}, 48'd0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    rst = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_lj();
    t_i2s();
    t_rj();
    t_junk();
    t_lanes();
    t_alt_fmt();
    t_mid_reset();
    frame_check("R1 after reset", 2'd1, 2'd3, 24'h112233, 24'h445566, 24'h778899, 24'hAABBCC, 1'b0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule